// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO with Programmable Watermark Flag

This block is a 64-entry, 18-bit buffer between two clock domains. A producer pushes words on the load clock and a consumer pops them on the unload clock. The two clocks may be unrelated, or they may be one and the same. Both ends are stream interfaces. On the load side, a word is taken on a load-clock rising edge when `in_valid` and `in_ready` are both high. `in_ready` is low exactly while the buffer is full, and the producer must hold its word until it sees `in_ready` high. On the unload side, `out_valid` is high whenever a head word is on `out_data`. That word is consumed on an unload-clock rising edge where `out_ready` is high. The consumer may hold `out_ready` low for as long as it likes, and the head word then stays put. The head word is visible without any pop, so the read side works in fall-through style.

Besides the stream handshakes, the block drives four plain status pins. These are an active-low full, an active-low empty, a half-full indicator, and one shared watermark flag that reports "nearly empty or nearly full". The two watermark distances, called X for the low end and Y for the high end, can be loaded from the low byte of the write data right after reset. The producer does this by pushing with `prog_n` low before any data word has been stored. Without such a push, both distances are 8. An active-low output enable gates the data bus, and a separate drive-enable pin stands in for a three-state pad.

Top module: `dcfifo_top`

## Requirements
- R1: The buffer holds at most 64 words. `full_n` (and `in_ready`) go low once the stored count reaches 64 and stay high below that.
- R2: A push attempted while full changes nothing stored. A pop attempted while empty changes nothing, and `out_valid` stays low.
- R3: `half_full` is 1 while the count is 32 or more and 0 while it is 31 or less.
- R4: While `rst_n` is low, the block shows `full_n`=1, `empty_n`=0, `out_valid`=0, `half_full`=0, `almost_flag`=1 and `in_ready`=1, and both pointers are cleared.
- R5: `almost_flag` is 1 when the count is at most X or at least 64−Y, and 0 otherwise. With no programming, X = Y = 8.
- R6: After reset and before the first data word, the first push with `prog_n`=0 loads `in_data[7:0]` into both X and Y, and the second such push loads Y only. Neither push stores a word. Once both are loaded, a further push with `prog_n`=0 stores data.
- R7: The first word pushed into an empty buffer appears on `out_data` with `out_valid`=1, without any pop.
- R8: With `oe_n`=1, `out_drive` is 0 and `out_data` reads all zeros. With `oe_n`=0, `out_drive` is 1 and `out_data` carries the head word.
- R9: Words leave in exactly the order they were accepted. This holds when both clocks coincide, when they are unrelated, and under arbitrary valid/ready stalls.
- R10: After the first data word is stored, `prog_n` is ignored until the next reset. Pushes with `prog_n`=0 then store data, and X and Y keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ld_clk | input | 1 | Load (write) clock |
| ul_clk | input | 1 | Unload (read) clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| in_data | input | 18 | Word to push; bits 7..0 carry an offset during programming |
| in_valid | input | 1 | Producer has a word (or offset) this cycle |
| in_ready | output | 1 | Buffer can accept a push (equals `full_n`) |
| prog_n | input | 1 | Active-low: the push loads a watermark offset while the window is open |
| out_data | output | 18 | Head word, zero while output is disabled |
| out_valid | output | 1 | Head word is present (equals `empty_n`) |
| out_ready | input | 1 | Consumer pops the head word on this unload edge |
| oe_n | input | 1 | Active-low output enable |
| out_drive | output | 1 | Bus drive enable, high when `oe_n` is low |
| full_n | output | 1 | Low when 64 words are held |
| empty_n | output | 1 | Low when no word is held |
| half_full | output | 1 | High at 32 or more words |
| almost_flag | output | 1 | High when near empty (≤X) or near full (≥64−Y) |

## Verification
The bench walks the count through 8/9, 31/32, 55/56 and 63/64 with the default offsets. It then repeats the low and high edges with two programmed offsets and with one. A block with off-by-one comparisons would flip its flags a word early or late. One that mishandled the one-offset case would leave Y at 8 and raise the flag at 56 instead of 59. Pushes into a full buffer, pops from an empty one, a third `prog_n` push, and a `prog_n` push after data has been stored are all followed by a scoreboard drain. A design that wrapped a pointer, dropped a word, or swallowed a data word as an offset would then deliver a wrong or missing word. A long stalled stream on unrelated clocks catches broken pointer crossing as reordered or duplicated words.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  typedef enum logic [1:0] {
    PRG_SET_X = 2'd0,
    PRG_SET_Y = 2'd1,
    PRG_DONE  = 2'd2
  } prg_state_e;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dcfifo_sync2.sv
module dcfifo_sync2 #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // asynchronous read gives the fall-through head word
  assign rdata = mem[raddr];

endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
  import dcfifo_pkg::*;
#(
  parameter int AW    = 6,
  parameter int OFFW  = 8,
  parameter int DEF_X = 8,
  parameter int DEF_Y = 8
) (
  input  logic            ld_clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            prog_n,
  input  logic [OFFW-1:0] off_in,
  input  logic [AW:0]     rd_gray_s,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [AW:0]     wr_gray,
  output logic [AW:0]     wr_bin,
  output logic [AW:0]     wcount,
  output logic            full_n,
  output logic            half_full,
  output logic            almost_flag
);

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;
  localparam int CW    = ((OFFW > PW) ? OFFW : PW) + 2;

  prg_state_e      prg_q;
  logic [OFFW-1:0] off_x, off_y;
  logic [PW-1:0]   rd_bin_s, wr_bin_nxt;
  logic            full, prog_hit;
  logic [CW-1:0]   cnt_w, x_w, y_w;

  assign rd_bin_s   = PW'(from_gray(32'(rd_gray_s)));
  assign wcount     = wr_bin - rd_bin_s;
  assign full       = (wcount == PW'(DEPTH));
  assign wr_bin_nxt = wr_bin + 1'b1;
  assign wr_addr    = wr_bin[AW-1:0];

  // an offset capture never stores a word
  assign prog_hit = in_valid && !prog_n && (prg_q != PRG_DONE);
  assign wr_en    = in_valid && !full && !prog_hit;

  always_ff @(posedge ld_clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
      prg_q   <= PRG_SET_X;
      off_x   <= OFFW'(DEF_X);
      off_y   <= OFFW'(DEF_Y);
    end else if (wr_en) begin
      wr_bin  <= wr_bin_nxt;
      wr_gray <= PW'(to_gray(32'(wr_bin_nxt)));
      prg_q   <= PRG_DONE;
    end else if (prog_hit) begin
      case (prg_q)
        PRG_SET_X: begin
          off_x <= off_in;
          off_y <= off_in;
          prg_q <= PRG_SET_Y;
        end
        default: begin
          off_y <= off_in;
          prg_q <= PRG_DONE;
        end
      endcase
    end
  end

  assign cnt_w = CW'(wcount);
  assign x_w   = CW'(off_x);
  assign y_w   = CW'(off_y);

  assign full_n      = !full;
  assign half_full   = (wcount >= PW'(HALF));
  assign almost_flag = (cnt_w <= x_w) || ((cnt_w + y_w) >= CW'(DEPTH));

endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          ul_clk,
  input  logic          rst_n,
  input  logic          out_ready,
  input  logic [AW:0]   wr_gray_s,
  output logic [AW-1:0] rd_addr,
  output logic [AW:0]   rd_gray,
  output logic [AW:0]   rd_bin,
  output logic          empty_n
);

  localparam int PW = AW + 1;

  logic          empty, adv;
  logic [PW-1:0] rd_bin_nxt;

  assign empty      = (rd_gray == wr_gray_s);
  assign adv        = out_ready && !empty;
  assign rd_bin_nxt = rd_bin + 1'b1;
  assign rd_addr    = rd_bin[AW-1:0];
  assign empty_n    = !empty;

  always_ff @(posedge ul_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
    end else if (adv) begin
      rd_bin  <= rd_bin_nxt;
      rd_gray <= PW'(to_gray(32'(rd_bin_nxt)));
    end
  end

endmodule

// File: rtl/dcfifo_top.sv
module dcfifo_top #(
  parameter int DW    = 18,
  parameter int AW    = 6,
  parameter int OFFW  = 8,
  parameter int DEF_X = 8,
  parameter int DEF_Y = 8
) (
  input  logic          ld_clk,
  input  logic          ul_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          prog_n,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready,
  input  logic          oe_n,
  output logic          out_drive,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_full,
  output logic          almost_flag
);

  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [AW:0]   wr_gray, wr_bin, wcount, rd_gray, rd_bin;
  logic [AW:0]   wr_gray_s, rd_gray_s;
  logic [DW-1:0] head;

  dcfifo_wr_ctl #(.AW(AW), .OFFW(OFFW), .DEF_X(DEF_X), .DEF_Y(DEF_Y)) u_wr (
    .ld_clk(ld_clk), .rst_n(rst_n), .in_valid(in_valid), .prog_n(prog_n),
    .off_in(in_data[OFFW-1:0]), .rd_gray_s(rd_gray_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_gray(wr_gray), .wr_bin(wr_bin),
    .wcount(wcount), .full_n(full_n), .half_full(half_full),
    .almost_flag(almost_flag)
  );

  dcfifo_rd_ctl #(.AW(AW)) u_rd (
    .ul_clk(ul_clk), .rst_n(rst_n), .out_ready(out_ready),
    .wr_gray_s(wr_gray_s), .rd_addr(rd_addr), .rd_gray(rd_gray),
    .rd_bin(rd_bin), .empty_n(empty_n)
  );

  dcfifo_sync2 #(.W(AW + 1)) u_w2r (
    .clk(ul_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s)
  );

  dcfifo_sync2 #(.W(AW + 1)) u_r2w (
    .clk(ld_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s)
  );

  dcfifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(ld_clk), .we(wr_en), .waddr(wr_addr), .wdata(in_data),
    .raddr(rd_addr), .rdata(head)
  );

  assign in_ready  = full_n;
  assign out_valid = empty_n;
  assign out_drive = !oe_n;
  assign out_data  = oe_n ? '0 : head;

endmodule

// File: rtl/dcfifo_chk.sv
module dcfifo_chk #(
  parameter int AW = 6
) (
  input logic        ld_clk,
  input logic        ul_clk,
  input logic        rst_n,
  input logic        full_n,
  input logic        empty_n,
  input logic        half_full,
  input logic        almost_flag,
  input logic [AW:0] wr_bin,
  input logic [AW:0] rd_bin,
  input logic [AW:0] wcount
);

  localparam int DEPTH = 1 << AW;

  assert_no_overflow_R2: assert property (@(posedge ld_clk) disable iff (!rst_n)
    !full_n |=> $stable(wr_bin)) else $error("write pointer moved while full");

  assert_no_underflow_R2: assert property (@(posedge ul_clk) disable iff (!rst_n)
    !empty_n |=> $stable(rd_bin)) else $error("read pointer moved while empty");

  assert_count_bound_R1: assert property (@(posedge ld_clk) disable iff (!rst_n)
    wcount <= (AW+1)'(DEPTH)) else $error("count beyond depth");

  assert_full_half_R3: assert property (@(posedge ld_clk) disable iff (!rst_n)
    !full_n |-> half_full) else $error("full without half-full");

  assert_full_almost_R5: assert property (@(posedge ld_clk) disable iff (!rst_n)
    !full_n |-> almost_flag) else $error("full without watermark flag");

endmodule

bind dcfifo_top dcfifo_chk #(.AW(AW)) u_chk (
  .ld_clk(ld_clk), .ul_clk(ul_clk), .rst_n(rst_n), .full_n(full_n),
  .empty_n(empty_n), .half_full(half_full), .almost_flag(almost_flag),
  .wr_bin(wr_bin), .rd_bin(rd_bin), .wcount(wcount)
);

// File: tb/tb_dcfifo_top.sv
`timescale 1ns/1ps
module tb_dcfifo_top;

  logic        ld_clk = 0, ul_clk = 0, rst_n = 0;
  logic [17:0] in_data = '0;
  logic        in_valid = 0, prog_n = 1, out_ready = 0, oe_n = 0;
  logic        in_ready, out_valid, out_drive, full_n, empty_n, half_full, almost_flag;
  logic [17:0] out_data;
  int          ul_half = 10;
  int          n_checks = 0, n_fail = 0, n_pop = 0;
  bit          done = 0;
  logic [17:0] sb[$];

  dcfifo_top dut (
    .ld_clk(ld_clk), .ul_clk(ul_clk), .rst_n(rst_n), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .prog_n(prog_n),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .oe_n(oe_n), .out_drive(out_drive), .full_n(full_n), .empty_n(empty_n),
    .half_full(half_full), .almost_flag(almost_flag)
  );

  always #10 ld_clk = ~ld_clk;
  initial forever #(ul_half) ul_clk = ~ul_clk;

  task automatic checkv(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares every popped word in order
  always @(negedge ul_clk) begin
    if (rst_n && !oe_n && out_valid && out_ready) begin
      if (sb.size() == 0) checkv("R2 word from empty buffer", int'(out_data), -1);
      else begin
        checkv("R9 order", int'(out_data), int'(sb.pop_front()));
        n_pop++;
      end
    end
  end

  task automatic ld(input logic [17:0] d, input logic pg, input bit store, output bit took);
    @(negedge ld_clk);
    in_data = d; prog_n = pg; in_valid = 1'b1; took = in_ready;
    @(posedge ld_clk);
    #1; in_valid = 1'b0; prog_n = 1'b1;
    if (took && store) sb.push_back(d);
    #4;
  endtask

  task automatic wr(input logic [17:0] d);
    bit t;
    ld(d, 1'b1, 1'b1, t);
  endtask

  task automatic set_rdy(input logic v);
    @(posedge ul_clk); #1; out_ready = v;
  endtask

  task automatic do_reset();
    in_valid = 0; prog_n = 1; out_ready = 0; oe_n = 0;
    #3; rst_n = 0; sb.delete();
    repeat (3) @(negedge ld_clk);
    checkv("R4 full_n", full_n, 1);
    checkv("R4 empty_n", empty_n, 0);
    checkv("R4 out_valid", out_valid, 0);
    checkv("R4 half_full", half_full, 0);
    checkv("R4 almost_flag", almost_flag, 1);
    checkv("R4 in_ready", in_ready, 1);
    rst_n = 1;
    repeat (2) @(negedge ld_clk);
  endtask

  task automatic drain();
    set_rdy(1'b1);
    for (int k = 0; k < 4000 && sb.size() != 0; k++) @(negedge ul_clk);
    repeat (4) @(negedge ul_clk);
    checkv("R9 all words delivered", sb.size(), 0);
    set_rdy(1'b0);
  endtask

  task automatic fill_to(input int from, input int upto, input int lo, input int hi);
    // writes words from+1..upto, checking watermark at lo, lo+1, hi-1, hi
    for (int i = from + 1; i <= upto; i++) begin
      wr(18'(i * 41 + 7));
      if (i == lo)     checkv("R5 at low offset", almost_flag, 1);
      if (i == lo + 1) checkv("R5 above low offset", almost_flag, 0);
      if (i == hi - 1) checkv("R5 below high mark", almost_flag, 0);
      if (i == hi)     checkv("R5 at high mark", almost_flag, 1);
    end
  endtask

  initial begin
    bit t;
    // ---- default offsets, coincident clocks ----
    do_reset();
    wr(18'h2A5C3);
    repeat (4) @(negedge ul_clk);
    checkv("R7 fall-through valid", out_valid, 1);
    checkv("R7 fall-through data", int'(out_data), 'h2A5C3);
    @(negedge ld_clk);
    checkv("R5 count 1 almost", almost_flag, 1);
    for (int i = 2; i <= 64; i++) begin
      wr(18'(i * 13 + 3));
      if (i == 8)  checkv("R5 default X=8 at 8", almost_flag, 1);
      if (i == 9)  checkv("R5 default X=8 at 9", almost_flag, 0);
      if (i == 31) checkv("R3 half at 31", half_full, 0);
      if (i == 32) checkv("R3 half at 32", half_full, 1);
      if (i == 55) checkv("R5 default Y=8 at 55", almost_flag, 0);
      if (i == 56) checkv("R5 default Y=8 at 56", almost_flag, 1);
      if (i == 63) checkv("R1 not full at 63", full_n, 1);
      if (i == 64) begin
        checkv("R1 full at 64", full_n, 0);
        checkv("R1 in_ready low when full", in_ready, 0);
      end
    end
    ld(18'h3FFFF, 1'b1, 1'b1, t);
    checkv("R2 push while full refused", t, 0);
    checkv("R2 still full", full_n, 0);
    // output enable
    @(negedge ul_clk); oe_n = 1;
    @(negedge ul_clk);
    checkv("R8 drive off", out_drive, 0);
    checkv("R8 data zero", int'(out_data), 0);
    oe_n = 0;
    @(negedge ul_clk);
    checkv("R8 drive on", out_drive, 1);
    checkv("R8 head word", int'(out_data), int'(sb[0]));
    drain();
    set_rdy(1'b1);
    repeat (10) @(negedge ul_clk);
    checkv("R2 pops on empty keep out_valid low", out_valid, 0);
    wr(18'h15A5A);
    for (int k = 0; k < 50 && sb.size() != 0; k++) @(negedge ul_clk);
    checkv("R2 next word after empty pops", sb.size(), 0);
    set_rdy(1'b0);
    repeat (6) @(negedge ld_clk);
    checkv("R3 half low after drain", half_full, 0);
    checkv("R5 almost high after drain", almost_flag, 1);

    // ---- two offsets: X=3, Y=10 ----
    do_reset();
    ld(18'h3FF03, 1'b0, 1'b0, t);
    ld(18'h0010A, 1'b0, 1'b0, t);
    ld(18'h2AAAA, 1'b0, 1'b1, t);   // third prog push stores data (R6)
    checkv("R6 third prog push stored", int'(out_valid || 1) & (sb.size() == 1 ? 1 : 0), 1);
    fill_to(1, 60, 3, 54);
    drain();

    // ---- one offset: X=Y=5 ----
    do_reset();
    ld(18'h00005, 1'b0, 1'b0, t);
    fill_to(0, 60, 5, 59);
    drain();

    // ---- lockout after first data word ----
    do_reset();
    wr(18'h00111);
    ld(18'h00002, 1'b0, 1'b1, t);   // stored as data (R10)
    ld(18'h00030, 1'b0, 1'b1, t);
    checkv("R10 prog push after data is stored", sb.size(), 3);
    fill_to(3, 60, 8, 56);
    drain();

    // ---- unrelated clocks, stalls on both ends ----
    ul_half = 13;
    do_reset();
    n_pop = 0;
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          if (i % 5 == 3) @(negedge ld_clk);
          t = 0;
          while (!t) ld(18'(i * 97 + 5), 1'b1, 1'b1, t);
        end
      end
      begin
        for (int k = 0; k < 900; k++) begin
          @(posedge ul_clk); #1;
          out_ready = ((k % 7) != 2) && ((k / 40) % 4 != 1);
        end
      end
    join
    drain();
    checkv("R9 word count across clocks", n_pop, 300);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule